// File: doc/BRIEF.md
# Trap-Configuration Register Access Controller

This block owns a 64-bit configuration register that selects which system-register reads are trapped to the hypervisor. It also decides what happens to every read or write instruction that names this register. A request carries the instruction's five encoding fields, a read/write flag and write data. It is qualified by the processor context: the current privilege level (0 = application, 1 = guest kernel, 2 = hypervisor, 3 = top/secure monitor), the hypervisor-enabled flag, two nested-virtualization flags (`nv`, `nv2`), the top-level-present flag with its fine-grained-trap enable, the debug-halted flag and the secure-debug-disable flag.

One cycle after a matching request, the block reports exactly one outcome: undefined instruction, trap to the hypervisor, trap to the top level, redirect to a memory slot, or direct register access. Trap outcomes carry syndrome class 0x18. A redirect gives the slot offset 0x1B8, and for writes it also gives the data to store there. Delivering the exception and performing the memory access are left to the surrounding logic.

A parameter selects how the implementation ranks the halted-debug condition. When it is set, a halted core with secure debug disabled, a present top level and its fine-grained enable at 0 gets an undefined outcome at every privilege level. This check comes before all other rules.

Top module: `trapcfg_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cfg_q` is zero and `rsp_vld` is 0.
- R2: A request whose encoding is not op0=0b11, op1=0b100, CRn=0b0001, CRm=0b0001, op2=0b100 produces no response (`rsp_vld` stays 0) and leaves `cfg_q` unchanged.
- R3: A matching request at privilege level 0 yields undefined (`rsp_kind` = 5'b00001).
- R4: At level 1, with `hyp_en`, `nv` and `nv2` all 1, the outcome is redirect (`rsp_kind` = 5'b01000). `slot_off` is 0x1B8. A write raises `slot_wr` and presents its data on `slot_wdata`. A read leaves `slot_wr` at 0. `cfg_q` does not change.
- R5: At level 1, with `hyp_en`=1, `nv`=1 and `nv2`=0, the outcome is trap to hypervisor (`rsp_kind` = 5'b00010) with `rsp_class` = 0x18.
- R6: At level 1, every other flag combination yields undefined.
- R7: At level 2, with `top_present`=1 and `fgt_en`=0, the outcome is trap to top (`rsp_kind` = 5'b00100, class 0x18). The exception is a core that is both halted and secure-debug-disabled, which yields undefined instead.
- R8: At level 2 without that blocking condition, and always at level 3, the access is direct (`rsp_kind` = 5'b10000). A write stores the data. A read returns `cfg_q` on `rsp_rdata`.
- R9: With `HALT_FIRST`=1, the combination halted, secure-debug-disabled, top present and `fgt_en`=0 yields undefined at every level, including levels 1 and 3.
- R10: Bits 63..54 of the register always read as zero, and values written to them are discarded.
- R11: A response is valid exactly in the cycle after the request. During that cycle `rsp_kind` has exactly one bit set. `rsp_class` is 0 for every outcome other than a trap, and `rsp_kind` is 0 when there is no response.
- R12: The stored register changes only on a direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low warm reset |
| req_vld | input | 1 | Access request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write source data |
| cur_el | input | 2 | Current privilege level |
| hyp_en | input | 1 | Hypervisor enabled in current security state |
| nv | input | 1 | Nested-virtualization trap flag |
| nv2 | input | 1 | Nested-virtualization memory-redirect flag |
| top_present | input | 1 | Top privilege level implemented |
| fgt_en | input | 1 | Fine-grained-trap enable set by the top level |
| halted | input | 1 | Core in halted debug state |
| sdd | input | 1 | Secure debug disabled |
| rsp_vld | output | 1 | Outcome valid |
| rsp_kind | output | 5 | One-hot outcome: bit0 undef, bit1 trap hyp, bit2 trap top, bit3 redirect, bit4 direct |
| rsp_class | output | 6 | Syndrome class for trap outcomes |
| rsp_rdata | output | 64 | Register value for a direct read |
| slot_off | output | 12 | Memory slot offset for a redirect |
| slot_wr | output | 1 | Redirected write, store `slot_wdata` |
| slot_wdata | output | 64 | Data to store in the slot |
| cfg_q | output | 64 | Current register contents |

## Verification
The bench builds two copies side by side on the same stimulus. One uses `HALT_FIRST`=0 and the other `HALT_FIRST`=1, and both keep the 64-bit width with 54 implemented bits. With this pairing, the halted-debug inputs at levels 1 and 3 must give different outcomes from the two copies, which shows the ranking choice really changes behaviour. The two copies must still agree everywhere else. Because the implemented width is below the data width, an all-ones write exposes the reserved-bit masking.

// File: rtl/trapcfg_pkg.sv
package trapcfg_pkg;

   typedef enum logic [2:0] {
      KIND_UNDEF    = 3'd0,
      KIND_TRAP_HYP = 3'd1,
      KIND_TRAP_TOP = 3'd2,
      KIND_SLOT     = 3'd3,
      KIND_DIRECT   = 3'd4
   } kind_e;

   localparam int unsigned KIND_N = 5;

   localparam logic [5:0] TRAP_CLASS = 6'h18;

   typedef struct packed {
      logic [1:0] op0;
      logic [2:0] op1;
      logic [3:0] crn;
      logic [3:0] crm;
      logic [2:0] op2;
   } sysenc_t;

   localparam sysenc_t SELF_ENC = '{op0: 2'b11, op1: 3'b100, crn: 4'b0001,
                                    crm: 4'b0001, op2: 3'b100};

   typedef struct packed {
      logic [1:0] el;
      logic       hyp_en;
      logic       nv;
      logic       nv2;
      logic       top_present;
      logic       fgt_en;
      logic       halted;
      logic       sdd;
   } ctx_t;

endpackage

// File: rtl/trapcfg_match.sv
module trapcfg_match
   import trapcfg_pkg::*;
#(
   parameter sysenc_t TARGET = SELF_ENC
) (
   input  sysenc_t enc,
   output logic    hit
);
   localparam int unsigned ENC_W = $bits(sysenc_t);

   logic [ENC_W-1:0] diff;

   always_comb begin
      diff = enc ^ TARGET;
      hit  = (diff == '0);
   end

endmodule

// File: rtl/trapcfg_arbiter.sv
module trapcfg_arbiter
   import trapcfg_pkg::*;
#(
   parameter bit HALT_FIRST = 1'b0
) (
   input  ctx_t  ctx,
   output kind_e kind
);
   kind_e base_kind;
   logic  top_blocked;
   logic  dbg_locked;

   always_comb begin
      top_blocked = ctx.top_present & ~ctx.fgt_en;
      dbg_locked  = ctx.halted & ctx.sdd;
   end

   always_comb begin
      unique case (ctx.el)
         2'd0: base_kind = KIND_UNDEF;
         2'd1: begin
            if (ctx.hyp_en && ctx.nv && ctx.nv2)
               base_kind = KIND_SLOT;
            else if (ctx.hyp_en && ctx.nv)
               base_kind = KIND_TRAP_HYP;
            else
               base_kind = KIND_UNDEF;
         end
         2'd2: begin
            if (top_blocked)
               base_kind = dbg_locked ? KIND_UNDEF : KIND_TRAP_TOP;
            else
               base_kind = KIND_DIRECT;
         end
         default: base_kind = KIND_DIRECT;
      endcase
   end

   generate
      if (HALT_FIRST) begin : g_halt_first
         always_comb begin
            if (dbg_locked && top_blocked)
               kind = KIND_UNDEF;
            else
               kind = base_kind;
         end
      end else begin : g_level_order
         always_comb kind = base_kind;
      end
   endgenerate

endmodule

// File: rtl/trapcfg_store.sv
module trapcfg_store #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IMPL_W = 54
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam logic [DATA_W-1:0] IMPL_MASK =
      (IMPL_W >= DATA_W) ? {DATA_W{1'b1}} : ((DATA_W'(1) << IMPL_W) - DATA_W'(1));

   generate
      if (IMPL_W == 0 || IMPL_W > DATA_W) begin : g_bad_width
         $error("trapcfg_store: IMPL_W must be in 1..DATA_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (we)
         q <= wdata & IMPL_MASK;
   end

endmodule

// File: rtl/trapcfg_ctl.sv
module trapcfg_ctl
   import trapcfg_pkg::*;
#(
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned IMPL_W     = 54,
   parameter int unsigned OFF_W      = 12,
   parameter int unsigned SLOT_OFF   = 'h1B8,
   parameter bit          HALT_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic              req_wr,
   input  logic [1:0]        req_op0,
   input  logic [2:0]        req_op1,
   input  logic [3:0]        req_crn,
   input  logic [3:0]        req_crm,
   input  logic [2:0]        req_op2,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        cur_el,
   input  logic              hyp_en,
   input  logic              nv,
   input  logic              nv2,
   input  logic              top_present,
   input  logic              fgt_en,
   input  logic              halted,
   input  logic              sdd,
   output logic              rsp_vld,
   output logic [KIND_N-1:0] rsp_kind,
   output logic [5:0]        rsp_class,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [OFF_W-1:0]  slot_off,
   output logic              slot_wr,
   output logic [DATA_W-1:0] slot_wdata,
   output logic [DATA_W-1:0] cfg_q
);
   localparam logic [OFF_W-1:0] SLOT_OFF_V = OFF_W'(SLOT_OFF);

   generate
      if (SLOT_OFF >= (64'd1 << OFF_W)) begin : g_bad_off
         $error("trapcfg_ctl: SLOT_OFF does not fit in OFF_W bits");
      end
   endgenerate

   sysenc_t enc;
   ctx_t    ctx;
   logic    hit;
   kind_e   kind;
   logic    acc;
   logic    wr_direct;

   always_comb begin
      enc = '{op0: req_op0, op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};
      ctx = '{el: cur_el, hyp_en: hyp_en, nv: nv, nv2: nv2,
              top_present: top_present, fgt_en: fgt_en,
              halted: halted, sdd: sdd};
   end

   trapcfg_match #(.TARGET(SELF_ENC)) u_match (
      .enc (enc),
      .hit (hit)
   );

   trapcfg_arbiter #(.HALT_FIRST(HALT_FIRST)) u_arb (
      .ctx  (ctx),
      .kind (kind)
   );

   always_comb begin
      acc       = req_vld & hit;
      wr_direct = acc & req_wr & (kind == KIND_DIRECT);
   end

   trapcfg_store #(.DATA_W(DATA_W), .IMPL_W(IMPL_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_direct),
      .wdata (req_wdata),
      .q     (cfg_q)
   );

   kind_e kind_q;
   logic  vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q      <= 1'b0;
         kind_q     <= KIND_UNDEF;
         rsp_class  <= '0;
         rsp_rdata  <= '0;
         slot_off   <= '0;
         slot_wr    <= 1'b0;
         slot_wdata <= '0;
      end else begin
         vld_q      <= acc;
         kind_q     <= kind;
         rsp_class  <= (acc && (kind == KIND_TRAP_HYP || kind == KIND_TRAP_TOP))
                       ? TRAP_CLASS : 6'h00;
         rsp_rdata  <= (acc && !req_wr && kind == KIND_DIRECT) ? cfg_q : '0;
         slot_off   <= (acc && kind == KIND_SLOT) ? SLOT_OFF_V : '0;
         slot_wr    <= acc && req_wr && (kind == KIND_SLOT);
         slot_wdata <= (acc && req_wr && kind == KIND_SLOT) ? req_wdata : '0;
      end
   end

   assign rsp_vld = vld_q;

   generate
      for (genvar k = 0; k < KIND_N; k++) begin : g_onehot
         assign rsp_kind[k] = vld_q && (kind_q == kind_e'(k));
      end
   endgenerate

endmodule

// File: rtl/trapcfg_ctl_chk.sv
module trapcfg_ctl_chk #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IMPL_W = 54
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic              req_wr,
   input logic [1:0]        cur_el,
   input logic              rsp_vld,
   input logic [4:0]        rsp_kind,
   input logic [5:0]        rsp_class,
   input logic              slot_wr,
   input logic [DATA_W-1:0] cfg_q
);
   // R11
   kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> ($countones(rsp_kind) == 1));

   // R11
   kind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_vld |-> (rsp_kind == 5'b00000));

   // R11
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |-> $past(req_vld));

   // R3
   low_level_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && cur_el == 2'd0) |=> (!rsp_vld || rsp_kind == 5'b00001));

   // R5
   trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld && (rsp_kind[1] || rsp_kind[2])) |-> (rsp_class == 6'h18));

   // R11
   nontrap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_vld && (rsp_kind[1] || rsp_kind[2])) |-> (rsp_class == 6'h00));

   // R4
   slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_wr |-> (rsp_kind == 5'b01000 && $past(req_wr)));

   // R12
   update_only_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q != $past(cfg_q)) |-> (rsp_vld && rsp_kind == 5'b10000 && $past(req_wr)));

   generate
      if (IMPL_W < DATA_W) begin : g_resv
         // R10
         reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[DATA_W-1:IMPL_W] == '0);
      end
   endgenerate

endmodule

bind trapcfg_ctl trapcfg_ctl_chk #(.DATA_W(DATA_W), .IMPL_W(IMPL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_vld   (req_vld),
   .req_wr    (req_wr),
   .cur_el    (cur_el),
   .rsp_vld   (rsp_vld),
   .rsp_kind  (rsp_kind),
   .rsp_class (rsp_class),
   .slot_wr   (slot_wr),
   .cfg_q     (cfg_q)
);

// File: tb/sim_trapcfg_ctl.sv
`timescale 1ns/1ps
module sim_trapcfg_ctl;
   localparam real HALF = 2.5;

   localparam logic [4:0] K_UNDEF = 5'b00001;
   localparam logic [4:0] K_THYP  = 5'b00010;
   localparam logic [4:0] K_TTOP  = 5'b00100;
   localparam logic [4:0] K_SLOT  = 5'b01000;
   localparam logic [4:0] K_DIR   = 5'b10000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_vld = 1'b0, req_wr = 1'b0;
   logic [1:0] op0 = 2'b11;
   logic [2:0] op1 = 3'b100;
   logic [3:0] crn = 4'b0001, crm = 4'b0001;
   logic [2:0] op2 = 3'b100;
   logic [63:0] wdata = '0;
   logic [1:0] el = 2'd0;
   logic hyp_en = 0, nv = 0, nv2 = 0, top_present = 0, fgt_en = 0, halted = 0, sdd = 0;

   logic        v0, v1, sw0, sw1;
   logic [4:0]  k0, k1;
   logic [5:0]  c0, c1;
   logic [63:0] rd0, rd1, swd0, swd1, cfg0, cfg1;
   logic [11:0] so0, so1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(HALF) clk = ~clk;

   trapcfg_ctl #(.HALT_FIRST(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
      .req_op0(op0), .req_op1(op1), .req_crn(crn), .req_crm(crm), .req_op2(op2),
      .req_wdata(wdata), .cur_el(el), .hyp_en(hyp_en), .nv(nv), .nv2(nv2),
      .top_present(top_present), .fgt_en(fgt_en), .halted(halted), .sdd(sdd),
      .rsp_vld(v0), .rsp_kind(k0), .rsp_class(c0), .rsp_rdata(rd0),
      .slot_off(so0), .slot_wr(sw0), .slot_wdata(swd0), .cfg_q(cfg0));

   trapcfg_ctl #(.HALT_FIRST(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
      .req_op0(op0), .req_op1(op1), .req_crn(crn), .req_crm(crm), .req_op2(op2),
      .req_wdata(wdata), .cur_el(el), .hyp_en(hyp_en), .nv(nv), .nv2(nv2),
      .top_present(top_present), .fgt_en(fgt_en), .halted(halted), .sdd(sdd),
      .rsp_vld(v1), .rsp_kind(k1), .rsp_class(c1), .rsp_rdata(rd1),
      .slot_off(so1), .slot_wr(sw1), .slot_wdata(swd1), .cfg_q(cfg1));

   task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", rq, got, exp);
      end
   endtask

   task automatic ctx(input logic [1:0] l, input logic h, input logic n, input logic n2,
                      input logic tp, input logic fe, input logic hl, input logic sd);
      el = l; hyp_en = h; nv = n; nv2 = n2;
      top_present = tp; fgt_en = fe; halted = hl; sdd = sd;
   endtask

   // one request: driven at a falling edge, captured at the next rising edge,
   // response sampled at the following falling edge
   task automatic access(input logic wr, input logic [63:0] d);
      @(negedge clk);
      req_vld = 1'b1; req_wr = wr; wdata = d;
      @(negedge clk);
      req_vld = 1'b0; req_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 cfg u0", cfg0, 64'h0);
      chk("R1 cfg u1", cfg1, 64'h0);
      chk("R1 vld u0", {63'h0, v0}, 64'h0);
      chk("R1 vld u1", {63'h0, v1}, 64'h0);
   endtask

   task automatic t_el0();
      ctx(2'd0, 1, 1, 1, 1, 1, 0, 0);
      access(1'b1, 64'h1234);
      chk("R3 kind u0", {59'h0, k0}, {59'h0, K_UNDEF});
      chk("R3 kind u1", {59'h0, k1}, {59'h0, K_UNDEF});
      chk("R3 no update", cfg0, 64'h0);
   endtask

   task automatic t_el2_direct();
      ctx(2'd2, 1, 0, 0, 1, 1, 0, 0);
      access(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R8 write kind", {59'h0, k0}, {59'h0, K_DIR});
      chk("R11 class zero on direct", {58'h0, c0}, 64'h0);
      chk("R10 masked store u0", cfg0, 64'h003F_FFFF_FFFF_FFFF);
      chk("R10 masked store u1", cfg1, 64'h003F_FFFF_FFFF_FFFF);
      access(1'b0, 64'h0);
      chk("R8 read data", rd0, 64'h003F_FFFF_FFFF_FFFF);
      @(negedge clk);
      chk("R11 vld drops", {63'h0, v0}, 64'h0);
      ctx(2'd2, 1, 0, 0, 1, 1, 0, 0);
      access(1'b1, 64'h0000_0000_A5A5_0F0F);
      chk("R8 second write", cfg0, 64'h0000_0000_A5A5_0F0F);
   endtask

   task automatic t_el2_blocked();
      ctx(2'd2, 1, 0, 0, 1, 0, 0, 0);
      access(1'b1, 64'h55);
      chk("R7 trap top kind", {59'h0, k0}, {59'h0, K_TTOP});
      chk("R7 trap top class", {58'h0, c0}, 64'h18);
      chk("R12 no update on trap", cfg0, 64'h0000_0000_A5A5_0F0F);
      ctx(2'd2, 1, 0, 0, 1, 0, 1, 1);
      access(1'b0, 64'h0);
      chk("R7 halted undef u0", {59'h0, k0}, {59'h0, K_UNDEF});
      chk("R7 halted undef u1", {59'h0, k1}, {59'h0, K_UNDEF});
      chk("R7 undef class", {58'h0, c0}, 64'h0);
      ctx(2'd2, 1, 0, 0, 1, 0, 1, 0);
      access(1'b0, 64'h0);
      chk("R7 halted only still traps", {59'h0, k0}, {59'h0, K_TTOP});
   endtask

   task automatic t_el1();
      ctx(2'd1, 1, 1, 1, 0, 0, 0, 0);
      access(1'b1, 64'hDEAD_BEEF_0000_0001);
      chk("R4 slot kind", {59'h0, k0}, {59'h0, K_SLOT});
      chk("R4 slot off", {52'h0, so0}, 64'h1B8);
      chk("R4 slot wr", {63'h0, sw0}, 64'h1);
      chk("R4 slot data", swd0, 64'hDEAD_BEEF_0000_0001);
      chk("R4 no reg update", cfg0, 64'h0000_0000_A5A5_0F0F);
      access(1'b0, 64'h0);
      chk("R4 slot read kind", {59'h0, k0}, {59'h0, K_SLOT});
      chk("R4 slot read no wr", {63'h0, sw0}, 64'h0);
      ctx(2'd1, 1, 1, 0, 0, 0, 0, 0);
      access(1'b0, 64'h0);
      chk("R5 trap hyp kind", {59'h0, k0}, {59'h0, K_THYP});
      chk("R5 trap hyp class", {58'h0, c0}, 64'h18);
      ctx(2'd1, 0, 1, 1, 0, 0, 0, 0);
      access(1'b0, 64'h0);
      chk("R6 hyp off undef", {59'h0, k0}, {59'h0, K_UNDEF});
      ctx(2'd1, 1, 0, 1, 0, 0, 0, 0);
      access(1'b1, 64'h77);
      chk("R6 nv off undef", {59'h0, k0}, {59'h0, K_UNDEF});
      chk("R12 no update on undef", cfg0, 64'h0000_0000_A5A5_0F0F);
   endtask

   task automatic t_halt_priority();
      ctx(2'd1, 1, 1, 1, 1, 0, 1, 1);
      access(1'b1, 64'h99);
      chk("R9 el1 u0 redirect", {59'h0, k0}, {59'h0, K_SLOT});
      chk("R9 el1 u1 undef", {59'h0, k1}, {59'h0, K_UNDEF});
      chk("R9 el1 u1 no slot wr", {63'h0, sw1}, 64'h0);
      ctx(2'd3, 0, 0, 0, 1, 0, 1, 1);
      access(1'b1, 64'h0000_0000_0000_0042);
      chk("R9 el3 u0 direct", {59'h0, k0}, {59'h0, K_DIR});
      chk("R9 el3 u1 undef", {59'h0, k1}, {59'h0, K_UNDEF});
      chk("R8 el3 write u0", cfg0, 64'h42);
      chk("R9 el3 u1 kept", cfg1, 64'h0000_0000_A5A5_0F0F);
      ctx(2'd3, 0, 0, 0, 1, 1, 1, 1);
      access(1'b0, 64'h0);
      chk("R9 enabled u1 direct", {59'h0, k1}, {59'h0, K_DIR});
      chk("R8 el3 read u1", rd1, 64'h0000_0000_A5A5_0F0F);
   endtask

   task automatic t_encoding();
      ctx(2'd3, 0, 0, 0, 0, 0, 0, 0);
      op2 = 3'b101;
      access(1'b1, 64'hFFFF);
      chk("R2 no rsp", {63'h0, v0}, 64'h0);
      chk("R2 no update", cfg0, 64'h42);
      op2 = 3'b100; crm = 4'b0010;
      access(1'b1, 64'hFFFF);
      chk("R2 no rsp crm", {63'h0, v1}, 64'h0);
      chk("R2 no update crm", cfg1, 64'h0000_0000_A5A5_0F0F);
      crm = 4'b0001;
   endtask

   initial begin
      #(HALF * 2 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired got running exp finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_el0();
      t_el2_direct();
      t_el2_blocked();
      t_el1();
      t_halt_priority();
      t_encoding();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule